// File: doc/BRIEF.md
# Register-Triggered I2C Master Byte Engine

This block is the bus side of an I2C master. It transfers one byte at a time, and each transfer starts as a side effect of a processor access to a single data register. No explicit start command exists. A level control `cfg_master` claims the bus with a START and gives it back with a STOP. A second level `cfg_xmit` selects the direction, and an access starts a byte only when it agrees with that bit. A write while transmitting sends the written byte. A read while receiving fetches the next byte from the target.

The first byte written after the bus is claimed is the address byte. It carries the 7-bit target address in bits 7..1 and the read/write flag in bit 0. Reads are refused until that byte has gone out. Between bytes the engine holds SCL low and waits for the next access. This lets software switch `cfg_xmit` back to transmit before its last read of a receive sequence, so that the read only fetches data and does not start another byte.

Both lines are open drain. The block outputs pull-low enables and reads SDA back through `sda_in`. Every bit lasts four quarter periods of `QTR_DIV` system clocks each.

Top module: `i2c_reg_byte_master`

## Requirements
- R1: A rising `cfg_master` while the bus is idle produces a START: SDA falls while SCL is released high, then SCL is pulled low and held low until the next byte or the STOP.
- R2: While holding with `cfg_xmit`=1, a pulse on `dr_wr` sends `dr_wdata` as eight clocks, most significant bit first, followed by a ninth clock during which the master releases SDA so the target can acknowledge.
- R3: The first byte written after a START is put on the bus as written (address in bits 7..1, R/W in bit 0). A `dr_rd` pulse before any byte has been written since that START starts nothing.
- R4: While holding with `cfg_xmit`=0, after the address byte, a pulse on `dr_rd` clocks in eight bits, most significant first, and presents them on `dr_rdata` when the byte completes.
- R5: An access whose direction disagrees with `cfg_xmit` starts nothing: a write while `cfg_xmit`=0, a read while `cfg_xmit`=1, and any access while `cfg_master`=0. `busy` stays 0 and SCL does not pulse.
- R6: `dr_rdata` changes only at the end of a received byte. Writes and transmitted bytes never alter it.
- R7: In a received byte the master pulls SDA low in the ninth clock when `cfg_noack` is 0, and releases it when `cfg_noack` is 1. The value is captured when the byte starts.
- R8: `xfer_done` rises exactly 36×`QTR_DIV` clocks after the clock edge that accepted the access. It clears on the next accepted access or START. `ack_miss` holds the SDA level sampled in the ninth clock (1 = line high, not acknowledged).
- R9: After reset, and after a falling `cfg_master` while holding, both pull enables are 0 and `busy` is 0. The STOP raises SDA while SCL is high.
- R10: SDA changes only while SCL is low, except for the START and STOP edges. SCL stays high for 2×`QTR_DIV` clocks in every data bit.
- R11: While `busy`=1, data-register accesses are ignored: the byte in flight completes unchanged and no second byte follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | Master enable level; rise claims the bus, fall releases it |
| cfg_xmit | input | 1 | Direction: 1 transmit, 0 receive |
| cfg_noack | input | 1 | 1: answer the next received byte with NACK |
| dr_wr | input | 1 | One-cycle data register write strobe |
| dr_wdata | input | 8 | Byte to transmit |
| dr_rd | input | 1 | One-cycle data register read strobe |
| dr_rdata | output | 8 | Most recently received byte |
| busy | output | 1 | START, byte or STOP in progress |
| xfer_done | output | 1 | Byte complete flag |
| ack_miss | output | 1 | SDA level sampled in the ninth clock |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
`busy` is due one clock after the edge that accepts an access. `xfer_done`, `ack_miss` and a new `dr_rdata` are all due at the edge 36×`QTR_DIV` clocks after it, and the checks count clocks to that edge rather than waiting loosely. Refused accesses are judged a few quarter periods later by the absence of any SCL rise and a low `busy`. Line events are checked as they happen on the resolved bus: START and STOP counts, SCL high width, and the nine bits captured by a target model at each SCL rise. All outputs are sampled on the falling clock edge, half a cycle after they settle.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_XFER,
        ST_STOP
    } bus_state_t;

    // quarter periods of one SCL bit: two low, then two high
    typedef enum logic [1:0] {Q0, Q1, Q2, Q3} quarter_t;

    typedef struct packed {
        logic rx;
        logic noack;
    } xfer_cfg_t;

    function automatic logic bus_moving(bus_state_t s);
        return (s == ST_START) || (s == ST_XFER) || (s == ST_STOP);
    endfunction

    // SDA pull for one bit slot: data bits in transmit, acknowledge in receive
    function automatic logic bit_pull(xfer_cfg_t c, logic [BIT_CNT_W-1:0] idx, logic msb);
        if (idx == ACK_SLOT) return c.rx && !c.noack;
        return !c.rx && !msb;
    endfunction

endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
    parameter int QTR_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (QTR_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(QTR_DIV);
            localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);
            logic [CW-1:0] cnt;

            assign tick = run && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run || tick) cnt <= '0;
                else                     cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/i2c_bm_ctrl.sv
module i2c_bm_ctrl
    import i2c_bm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mst,
    input  logic                 xmit,
    input  logic                 wr,
    input  logic                 rd,
    input  logic                 tick,
    output bus_state_t           state,
    output quarter_t             qtr,
    output logic [BIT_CNT_W-1:0] bidx,
    output logic                 launch,
    output logic                 launch_rx,
    output logic                 byte_end,
    output logic                 done
);
    logic addr_sent;
    logic launch_tx;
    logic qend;

    assign launch_tx = (state == ST_HOLD) && mst && wr && xmit;
    assign launch_rx = (state == ST_HOLD) && mst && rd && !xmit && addr_sent;
    assign launch    = launch_tx || launch_rx;
    assign qend      = tick && (qtr == Q3);
    assign byte_end  = (state == ST_XFER) && qend && (bidx == ACK_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            qtr       <= Q0;
            bidx      <= '0;
            done      <= 1'b0;
            addr_sent <= 1'b0;
        end else begin
            if (tick) qtr <= quarter_t'(qtr + 2'd1);
            unique case (state)
                ST_IDLE: if (mst) begin
                    state     <= ST_START;
                    done      <= 1'b0;
                    addr_sent <= 1'b0;
                end
                ST_START: if (qend) state <= ST_HOLD;
                ST_HOLD: begin
                    if (!mst) begin
                        state <= ST_STOP;
                    end else if (launch) begin
                        state <= ST_XFER;
                        bidx  <= '0;
                        done  <= 1'b0;
                        if (launch_tx) addr_sent <= 1'b1;
                    end
                end
                ST_XFER: if (qend) begin
                    if (bidx == ACK_SLOT) begin
                        state <= ST_HOLD;
                        done  <= 1'b1;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                ST_STOP: if (qend) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a read while transmit is selected never starts a byte
    a_r5_read_in_tx_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && mst && rd && xmit && !wr) |=> (state != ST_XFER));

    // R3: no receive before the address byte of this session
    a_r3_read_needs_address: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && rd && !wr && !addr_sent) |=> (state != ST_XFER));

    // R8: the complete flag is low for the whole byte in flight
    a_r8_done_low_in_byte: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER) |-> !done);

    // R8: the complete flag rises only after the ninth clock
    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state) == ST_XFER && $past(bidx) == ACK_SLOT));
endmodule

// File: rtl/i2c_bm_shift.sv
module i2c_bm_shift
    import i2c_bm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_state_t           state,
    input  quarter_t             qtr,
    input  logic [BIT_CNT_W-1:0] bidx,
    input  logic                 tick,
    input  logic                 launch,
    input  logic                 launch_rx,
    input  logic                 byte_end,
    input  logic                 noack,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic                 sda_in,
    output logic                 scl_pull,
    output logic                 sda_pull,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 miss
);
    xfer_cfg_t         cfg;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            sh       <= '0;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            rdata    <= '0;
            miss     <= 1'b0;
        end else begin
            if (launch) begin
                cfg <= '{rx: launch_rx, noack: noack};
                sh  <= launch_rx ? '0 : wdata;
            end
            if (tick) begin
                unique case (state)
                    ST_START: case (qtr)
                        Q0:      sda_pull <= 1'b1;
                        Q1:      scl_pull <= 1'b1;
                        default: ;
                    endcase
                    ST_XFER: case (qtr)
                        Q0: sda_pull <= bit_pull(cfg, bidx, sh[BYTE_W-1]);
                        Q1: scl_pull <= 1'b0;
                        Q2: begin
                            if (bidx == ACK_SLOT) miss <= sda_in;
                            else                  sh   <= {sh[BYTE_W-2:0], sda_in};
                        end
                        Q3: scl_pull <= 1'b1;
                    endcase
                    ST_STOP: case (qtr)
                        Q0:      sda_pull <= 1'b1;
                        Q1:      scl_pull <= 1'b0;
                        Q2:      sda_pull <= 1'b0;
                        default: ;
                    endcase
                    default: ;
                endcase
            end
            if (byte_end && cfg.rx) rdata <= sh;
        end
    end

    // R10: SDA moves under a low SCL, except for the START and STOP edges
    a_r10_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> ($past(scl_pull) || $past(state) == ST_START || $past(state) == ST_STOP));

    // R1: between bytes the clock line is held low
    a_r1_hold_clock_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> scl_pull);

    // R9: an idle bus has both lines released
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!scl_pull && !sda_pull));
endmodule

// File: rtl/i2c_reg_byte_master.sv
module i2c_reg_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int QTR_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_master,
    input  logic       cfg_xmit,
    input  logic       cfg_noack,
    input  logic       dr_wr,
    input  logic [7:0] dr_wdata,
    input  logic       dr_rd,
    output logic [7:0] dr_rdata,
    output logic       busy,
    output logic       xfer_done,
    output logic       ack_miss,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    bus_state_t           state;
    quarter_t             qtr;
    logic [BIT_CNT_W-1:0] bidx;
    logic                 tick;
    logic                 launch;
    logic                 launch_rx;
    logic                 byte_end;

    assign busy = bus_moving(state);

    i2c_bm_tick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    i2c_bm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mst       (cfg_master),
        .xmit      (cfg_xmit),
        .wr        (dr_wr),
        .rd        (dr_rd),
        .tick      (tick),
        .state     (state),
        .qtr       (qtr),
        .bidx      (bidx),
        .launch    (launch),
        .launch_rx (launch_rx),
        .byte_end  (byte_end),
        .done      (xfer_done)
    );

    i2c_bm_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .qtr       (qtr),
        .bidx      (bidx),
        .tick      (tick),
        .launch    (launch),
        .launch_rx (launch_rx),
        .byte_end  (byte_end),
        .noack     (cfg_noack),
        .wdata     (dr_wdata),
        .sda_in    (sda_in),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .rdata     (dr_rdata),
        .miss      (ack_miss)
    );
endmodule

// File: tb/sim_i2c_reg_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_reg_byte_master;
    localparam int DIV      = 3;
    localparam int BYTE_CYC = 36 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mst = 1'b0, xmit = 1'b0, noack = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       busy, done, miss, scl_pull, sda_pull;
    logic       sl_pull = 1'b0;

    wire scl_line = ~scl_pull;
    wire sda_line = ~(sda_pull | sl_pull);

    always #2 clk = ~clk;

    i2c_reg_byte_master #(.QTR_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .cfg_master(mst), .cfg_xmit(xmit), .cfg_noack(noack),
        .dr_wr(wr), .dr_wdata(wdata), .dr_rd(rd), .dr_rdata(rdata), .busy(busy),
        .xfer_done(done), .ack_miss(miss), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- bus monitors ----------------
    int starts = 0, stops = 0, scl_rise = 0, hi_run = 0, last_hi = 0;
    always @(negedge sda_line) if (rst === 1'b0 && scl_line === 1'b1) starts++;
    always @(posedge sda_line) if (rst === 1'b0 && scl_line === 1'b1) stops++;
    always @(posedge scl_line) if (rst === 1'b0) scl_rise++;
    always @(negedge clk) begin
        if (scl_line === 1'b1) hi_run++;
        else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    end

    // ---------------- target model ----------------
    bit         sl_send = 1'b0;
    bit         sl_nack = 1'b0;
    logic [7:0] sl_byte = 8'h00;
    int         arm_cnt = 0;
    int         arm_seen = 0;
    int         sl_cnt = 0;
    bit         sl_active = 1'b0;
    logic       scl_prev = 1'b1;
    logic [8:0] cap = '0;

    function automatic logic sl_drive(int i);
        if (sl_send) return (i < 8) ? ~sl_byte[7-i] : 1'b0;
        return (i == 8) ? ~sl_nack : 1'b0;
    endfunction

    always @(scl_line or arm_cnt) begin
        if (arm_cnt != arm_seen) begin
            arm_seen  = arm_cnt;
            sl_cnt    = 0;
            cap       = '0;
            sl_active = 1'b1;
            sl_pull   = sl_drive(0);
        end else if (sl_active && scl_line === 1'b1 && scl_prev !== 1'b1) begin
            cap    = {cap[7:0], sda_line};
            sl_cnt = sl_cnt + 1;
        end else if (sl_active && scl_line === 1'b0 && scl_prev === 1'b1) begin
            if (sl_cnt >= 9) begin
                sl_pull   = 1'b0;
                sl_active = 1'b0;
            end else begin
                sl_pull = sl_drive(sl_cnt);
            end
        end
        scl_prev = scl_line;
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse(input bit is_rd, input logic [7:0] d);
        @(negedge clk);
        if (is_rd) rd = 1'b1; else begin wr = 1'b1; wdata = d; end
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic wait_quiet();
        while (busy) @(negedge clk);
    endtask

    task automatic refused(input bit is_rd, input string req);
        int r0;
        r0 = scl_rise;
        pulse(is_rd, 8'hC3);
        repeat (4 * DIV) @(negedge clk);
        chk(req, "busy after refused access", busy, 0);
        chk(req, "SCL rises after refused access", scl_rise - r0, 0);
    endtask

    task automatic run_byte(input bit is_rd, input logic [7:0] d, input bit snack,
                            input logic [7:0] sbyte, input bit disturb, input string req,
                            output int lat);
        @(negedge clk);
        sl_send = is_rd; sl_nack = snack; sl_byte = sbyte;
        arm_cnt++;
        if (is_rd) rd = 1'b1; else begin wr = 1'b1; wdata = d; end
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        chk(req, "busy one cycle after access", busy, 1);
        chk("R8", "done cleared by access", done, 0);
        lat = 0;
        while (!done && lat < 4 * BYTE_CYC) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (disturb && lat == 10) begin
                wr = 1'b1; rd = 1'b1; wdata = ~d; noack = ~noack;
            end else begin
                wr = 1'b0; rd = 1'b0;
            end
        end
        wr = 1'b0; rd = 1'b0;
        chk("R8", "done latency", lat, BYTE_CYC);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int lat;
        logic [7:0] last_rx;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "scl_pull after reset", scl_pull, 0);
        chk("R9", "sda_pull after reset", sda_pull, 0);
        chk("R9", "busy after reset", busy, 0);
        chk("R8", "done after reset", done, 0);
        chk("R6", "rdata after reset", rdata, 0);

        xmit = 1'b1;
        refused(1'b0, "R5");          // master not enabled

        // START
        @(negedge clk); mst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "busy during START", busy, 1);
        wait_quiet();
        chk("R1", "START count", starts, 1);
        chk("R1", "SCL held low", scl_pull, 1);
        chk("R1", "SDA held low", sda_pull, 1);
        chk("R1", "no STOP yet", stops, 0);

        xmit = 1'b0;
        refused(1'b1, "R3");          // read before the address byte

        // address byte
        xmit = 1'b1;
        run_byte(1'b0, 8'hA1, 1'b0, 8'h00, 1'b0, "R3", lat);
        chk("R3", "address byte on the bus", int'(cap[8:1]), 8'hA1);
        chk("R2", "ninth clock acked by target", cap[0], 0);
        chk("R8", "ack_miss on ack", miss, 0);
        chk("R10", "SCL high width", last_hi, 2 * DIV);

        // transmit sweep, target acks on even values
        for (int v = 0; v < 256; v++) begin
            run_byte(1'b0, v[7:0], v[0], 8'h00, 1'b0, "R2", lat);
            chk("R2", "byte shifted out MSB first", int'(cap[8:1]), v);
            chk("R8", "ack_miss follows ninth clock", miss, v[0]);
            chk("R6", "rdata untouched by writes", rdata, 0);
        end

        // accesses during a byte are ignored
        run_byte(1'b0, 8'h5A, 1'b0, 8'h00, 1'b1, "R11", lat);
        noack = 1'b0;
        chk("R11", "byte in flight unchanged", int'(cap[8:1]), 8'h5A);
        repeat (2) @(negedge clk);
        chk("R11", "no second byte", busy, 0);

        refused(1'b1, "R5");          // read while transmit selected

        xmit = 1'b0;
        refused(1'b0, "R5");          // write while receive selected

        // receive sweep
        for (int v = 0; v < 256; v++) begin
            noack = v[1];
            run_byte(1'b1, 8'h00, 1'b0, v[7:0], 1'b0, "R4", lat);
            chk("R4", "received byte", rdata, v);
            chk("R7", "master ack level", cap[0], v[1]);
            chk("R8", "ack_miss in receive", miss, v[1]);
        end

        // noack captured at launch
        noack = 1'b0;
        run_byte(1'b1, 8'h00, 1'b0, 8'h96, 1'b1, "R7", lat);
        noack = 1'b0;
        chk("R7", "ack kept despite later noack change", cap[0], 0);
        chk("R11", "received byte unchanged by disturbance", rdata, 8'h96);
        repeat (2) @(negedge clk);
        chk("R11", "no extra receive", busy, 0);
        last_rx = rdata;

        // leaving receive: switch direction first, then read
        xmit = 1'b1;
        refused(1'b1, "R5");
        chk("R6", "final read returns last byte", rdata, last_rx);
        run_byte(1'b0, 8'h77, 1'b0, 8'h00, 1'b0, "R2", lat);
        chk("R6", "rdata kept over transmit", rdata, last_rx);

        // STOP
        @(negedge clk); mst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9", "busy during STOP", busy, 1);
        wait_quiet();
        chk("R9", "STOP count", stops, 1);
        chk("R9", "SCL released", scl_pull, 0);
        chk("R9", "SDA released", sda_pull, 0);

        // second session: address gating resets, done cleared by START
        @(negedge clk); mst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8", "done cleared by START", done, 0);
        wait_quiet();
        xmit = 1'b0;
        refused(1'b1, "R3");
        @(negedge clk); mst = 1'b0;
        @(posedge clk); @(negedge clk);
        wait_quiet();
        chk("R10", "SDA falls under high SCL only at START", starts, 2);
        chk("R10", "SDA rises under high SCL only at STOP", stops, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL R11 watchdog: got %0d cycles expected completion sooner", 190000);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end
endmodule